// File: doc/BRIEF.md
# Dual Trigger Marker Generator for Chip-Rate Frame Timing

This block keeps one chip-rate timebase for a spread-spectrum waveform and turns it into two trigger marker outputs. From a count of chips it derives slot starts, radio-frame starts, the wrap of the 4096-frame system frame number, and the start of each repetition of two independently sized chip sequences, a normal one and an enhanced one. Every marker is one chip wide and lands on the first chip of its period.

Each of the two outputs picks one of those events through its own 3-bit source code. It can then postpone the event by a whole number of chips and can invert the result. The delay does not use a per-chip shift register. Each output keeps a small queue of event timestamps taken from a free-running chip counter, and a queued event leaves the queue on the chip where its age equals the programmed delay.

A synchronous restart puts the whole timebase at chip 0 of slot 0 of frame 0 with SFN 0, and both sequence counters at their start. All markers therefore line up on that chip. Periods are counted in chips, so the real-time values (0.667 ms per slot, 10 ms per frame) hold only at the nominal 3.84 Mcps rate.

Top module: `tmg_trigger_gen`

## Requirements
- R1: The slot event is true on chip 0 of every slot, which is once every SLOT_CHIPS chips (2560 by default).
- R2: The frame event is true on chip 0 of slot 0, which is once every SLOT_CHIPS*SLOTS_PER_FRAME chips (38400 by default).
- R3: The SFN-restart event is true on the first chip of the frame whose frame number has wrapped to 0. This happens once every SFN_FRAMES frames (4096 by default).
- R4: The sequence event (code 2) fires every `seq_len` chips and the enhanced-sequence event (code 3) fires every `eseq_len` chips, each on the first chip of a repetition. A length of 0 or 1 makes the event fire on every chip.
- R5: The select codes are 0 slot, 1 frame, 2 sequence, 3 enhanced sequence and 4 SFN restart. Codes 5, 6 and 7 hold the marker inactive.
- R6: Polarity bit 0 drives the marker active-high. Polarity bit 1 drives the inverted marker, so an inactive output then sits high.
- R7: The delay field postpones the selected marker by that many chips, and 0 means no delay. Values above FRAME_CHIPS-1 act as FRAME_CHIPS-1.
- R8: All counters advance only on cycles with `chip_en` high. While `chip_en` is low the outputs hold the value of the current chip.
- R9: `restart` sets every counter to its start and discards all pending delayed events. On the chip after restart, every source marker is active.
- R10: Each output holds at most DEPTH pending delayed events. An event that finds the queue full is dropped, unless a pending event leaves the queue on the same chip.
- R11: While the asynchronous reset is asserted, the block is in the same state it has after a restart.
- R12: The two outputs are independent. The source, polarity and delay of one output do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip strobe; one chip elapses per high cycle |
| restart | input | 1 | Synchronous timebase restart |
| seq_len | input | SEQ_W | Chip sequence period in chips |
| eseq_len | input | SEQ_W | Enhanced chip sequence period in chips |
| sel0 | input | 3 | Source code for output 0 |
| pol0 | input | 1 | Polarity of output 0 (1 = inverted) |
| dly0 | input | TS_W | Delay of output 0 in chips |
| sel1 | input | 3 | Source code for output 1 |
| pol1 | input | 1 | Polarity of output 1 (1 = inverted) |
| dly1 | input | TS_W | Delay of output 1 in chips |
| trig0 | output | 1 | Trigger marker output 0 |
| trig1 | output | 1 | Trigger marker output 1 |

## Verification
The bench shrinks the slot, frame and SFN sizes so that it can run through whole SFN cycles. It then checks every chip of each run against a model built from the requirements.

It aims at these corner cases:
- A delay at the largest allowed value, and a delay above it. A design without the clamp would fire late or never.
- Sequence lengths of 0 and 1. An off-by-one wrap would skip chips.
- Stalled chip strobes. A design that counts clock cycles would shift every marker.
- A restart with delayed events still queued. A design that keeps stale timestamps would emit a spurious pulse.
- A queue that overflows. The bench expects an exact gap pattern where events were dropped; a design that overwrites entries instead would show a different pattern.

// File: rtl/tmg_pkg.sv
`timescale 1ns/1ps
package tmg_pkg;

  typedef enum logic [2:0] {
    SRC_SLOT  = 3'd0,
    SRC_FRAME = 3'd1,
    SRC_SEQ   = 3'd2,
    SRC_ESEQ  = 3'd3,
    SRC_SFN   = 3'd4
  } src_e;

  typedef struct packed {
    logic slot;
    logic frame;
    logic seq;
    logic eseq;
    logic sfn;
  } evt_t;

endpackage

// File: rtl/tmg_timebase.sv
`timescale 1ns/1ps
module tmg_timebase #(
  parameter int SLOT_CHIPS      = 2560,
  parameter int SLOTS_PER_FRAME = 15,
  parameter int SFN_FRAMES      = 4096,
  parameter int TS_W            = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            restart,
  output logic            slot_ev,
  output logic            frame_ev,
  output logic            sfn_ev,
  output logic [TS_W-1:0] tstamp
);
  localparam int CW = $clog2(SLOT_CHIPS);
  localparam int SW = $clog2(SLOTS_PER_FRAME);
  localparam int FW = $clog2(SFN_FRAMES);
  localparam logic [CW-1:0] CHIP_LAST = CW'(SLOT_CHIPS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS_PER_FRAME - 1);
  localparam logic [FW-1:0] SFN_LAST  = FW'(SFN_FRAMES - 1);

  logic [CW-1:0]   chip_q, chip_d;
  logic [SW-1:0]   slot_q, slot_d;
  logic [FW-1:0]   sfn_q,  sfn_d;
  logic [TS_W-1:0] ts_q,   ts_d;
  logic            chip_last, slot_last, sfn_last;

  assign chip_last = (chip_q == CHIP_LAST);
  assign slot_last = (slot_q == SLOT_LAST);
  assign sfn_last  = (sfn_q  == SFN_LAST);

  always_comb begin
    chip_d = chip_q;
    slot_d = slot_q;
    sfn_d  = sfn_q;
    ts_d   = ts_q;
    if (restart) begin
      chip_d = '0;
      slot_d = '0;
      sfn_d  = '0;
      ts_d   = '0;
    end else if (chip_en) begin
      ts_d = ts_q + 1'b1;
      if (chip_last) begin
        chip_d = '0;
        if (slot_last) begin
          slot_d = '0;
          sfn_d  = sfn_last ? '0 : sfn_q + 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        chip_d = chip_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= '0;
      slot_q <= '0;
      sfn_q  <= '0;
      ts_q   <= '0;
    end else begin
      chip_q <= chip_d;
      slot_q <= slot_d;
      sfn_q  <= sfn_d;
      ts_q   <= ts_d;
    end
  end

  assign slot_ev  = (chip_q == '0);
  assign frame_ev = slot_ev && (slot_q == '0);
  assign sfn_ev   = frame_ev && (sfn_q == '0);
  assign tstamp   = ts_q;

  // R1: the last chip of a slot is followed by chip 0
  a_r1_chip_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !restart && chip_last) |=> (chip_q == '0));

  // R8: without a chip strobe the timebase holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !restart) |=> ($stable(chip_q) && $stable(slot_q) && $stable(sfn_q)));

  // R9: restart lands on the common origin
  a_r9_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sfn_ev && ts_q == '0));

  // R3: the frame number steps by one at each frame end until it wraps
  a_r3_sfn_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !restart && chip_last && slot_last && !sfn_last)
      |=> (sfn_q == $past(sfn_q) + 1'b1));
endmodule

// File: rtl/tmg_period_cnt.sv
`timescale 1ns/1ps
module tmg_period_cnt #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chip_en,
  input  logic         restart,
  input  logic [W-1:0] len,
  output logic         ev
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  // widened compare so that a length of 0 or 1 wraps on every chip
  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len};

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (chip_en) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ev = (cnt_q == '0);

  // R9: the sequence start follows a restart
  a_r9_seq_origin: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ev);

  // R4: short lengths keep the event on every chip
  a_r4_short_len: assert property (@(posedge clk) disable iff (!rst_n)
    (len <= W'(1) && $stable(len) && !restart && chip_en) |=> ev);
endmodule

// File: rtl/tmg_delay_line.sv
`timescale 1ns/1ps
module tmg_delay_line #(
  parameter int TS_W  = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            restart,
  input  logic            ev,
  input  logic [TS_W-1:0] dly,
  input  logic [TS_W-1:0] tstamp,
  output logic            fire
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [TS_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [PW:0]     cnt_q, cnt_d;
  logic [TS_W-1:0] age;
  logic            pop, push;

  assign age  = tstamp - mem_q[rd_q];
  assign fire = (cnt_q != '0) && (age == dly);
  assign pop  = chip_en && !restart && fire;
  assign push = chip_en && !restart && ev && ((cnt_q != FULL) || pop);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (restart) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= tstamp;
  end

  // R10: occupancy never exceeds the queue depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R10: a full queue with nothing leaving stays full
  a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && chip_en && !restart && !fire) |=> (cnt_q == FULL));

  // R9: restart empties the queue
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !fire));
endmodule

// File: rtl/tmg_trigger_out.sv
`timescale 1ns/1ps
module tmg_trigger_out
  import tmg_pkg::*;
#(
  parameter int TS_W        = 16,
  parameter int DEPTH       = 16,
  parameter int FRAME_CHIPS = 38400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            restart,
  input  evt_t            evt,
  input  logic [2:0]      sel,
  input  logic            pol,
  input  logic [TS_W-1:0] dly_raw,
  input  logic [TS_W-1:0] tstamp,
  output logic            trig
);
  localparam logic [TS_W-1:0] DMAX = TS_W'(FRAME_CHIPS - 1);

  logic [TS_W-1:0] dly;
  logic            ev_sel, direct, fire, marker;

  assign dly    = (dly_raw > DMAX) ? DMAX : dly_raw;
  assign direct = (dly == '0);

  always_comb begin
    case (sel)
      SRC_SLOT:  ev_sel = evt.slot;
      SRC_FRAME: ev_sel = evt.frame;
      SRC_SEQ:   ev_sel = evt.seq;
      SRC_ESEQ:  ev_sel = evt.eseq;
      SRC_SFN:   ev_sel = evt.sfn;
      default:   ev_sel = 1'b0;
    endcase
  end

  tmg_delay_line #(.TS_W(TS_W), .DEPTH(DEPTH)) u_dl (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .restart (restart),
    .ev      (ev_sel && !direct),
    .dly     (dly),
    .tstamp  (tstamp),
    .fire    (fire)
  );

  assign marker = direct ? ev_sel : fire;
  assign trig   = marker ^ pol;

  // R5: unused source codes leave the output at its inactive level
  a_r5_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > 3'd4) |-> (trig == pol));

  // R7: an undelayed slot selection follows the timebase event
  a_r7_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_raw == '0 && sel == 3'd0) |-> ((trig ^ pol) == evt.slot));
endmodule

// File: rtl/tmg_trigger_gen.sv
`timescale 1ns/1ps
module tmg_trigger_gen
  import tmg_pkg::*;
#(
  parameter int SLOT_CHIPS      = 2560,
  parameter int SLOTS_PER_FRAME = 15,
  parameter int SFN_FRAMES      = 4096,
  parameter int SEQ_W           = 20,
  parameter int DEPTH           = 16,
  parameter int NOUT            = 2,
  parameter int FRAME_CHIPS     = SLOT_CHIPS * SLOTS_PER_FRAME,
  parameter int TS_W            = $clog2(FRAME_CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             restart,
  input  logic [SEQ_W-1:0] seq_len,
  input  logic [SEQ_W-1:0] eseq_len,
  input  logic [2:0]       sel0,
  input  logic             pol0,
  input  logic [TS_W-1:0]  dly0,
  input  logic [2:0]       sel1,
  input  logic             pol1,
  input  logic [TS_W-1:0]  dly1,
  output logic             trig0,
  output logic             trig1
);
  evt_t            evt;
  logic [TS_W-1:0] tstamp;
  logic [2:0]      sel_a [NOUT];
  logic            pol_a [NOUT];
  logic [TS_W-1:0] dly_a [NOUT];
  logic            trig_a [NOUT];

  tmg_timebase #(
    .SLOT_CHIPS      (SLOT_CHIPS),
    .SLOTS_PER_FRAME (SLOTS_PER_FRAME),
    .SFN_FRAMES      (SFN_FRAMES),
    .TS_W            (TS_W)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .restart  (restart),
    .slot_ev  (evt.slot),
    .frame_ev (evt.frame),
    .sfn_ev   (evt.sfn),
    .tstamp   (tstamp)
  );

  tmg_period_cnt #(.W(SEQ_W)) u_seq (
    .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .restart (restart),
    .len (seq_len), .ev (evt.seq)
  );

  tmg_period_cnt #(.W(SEQ_W)) u_eseq (
    .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .restart (restart),
    .len (eseq_len), .ev (evt.eseq)
  );

  assign sel_a[0] = sel0;
  assign pol_a[0] = pol0;
  assign dly_a[0] = dly0;
  assign sel_a[1] = sel1;
  assign pol_a[1] = pol1;
  assign dly_a[1] = dly1;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    tmg_trigger_out #(
      .TS_W        (TS_W),
      .DEPTH       (DEPTH),
      .FRAME_CHIPS (FRAME_CHIPS)
    ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .chip_en (chip_en),
      .restart (restart),
      .evt     (evt),
      .sel     (sel_a[g]),
      .pol     (pol_a[g]),
      .dly_raw (dly_a[g]),
      .tstamp  (tstamp),
      .trig    (trig_a[g])
    );
  end

  assign trig0 = trig_a[0];
  assign trig1 = trig_a[1];

  // R12: identical settings on both outputs give identical markers
  a_r12_match: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == sel1 && pol0 == pol1 && dly0 == '0 && dly1 == '0) |-> (trig0 == trig1));
endmodule

// File: tb/sim_tmg_trigger_gen.sv
`timescale 1ns/1ps
module sim_tmg_trigger_gen;
  localparam int SC   = 16;
  localparam int SPF  = 3;
  localparam int NF   = 4;
  localparam int FR   = SC * SPF;
  localparam int SFNP = FR * NF;
  localparam int SW   = 8;
  localparam int TW   = $clog2(FR);

  logic clk = 1'b0;
  logic rst_n, chip_en, restart;
  logic [SW-1:0] seq_len, eseq_len;
  logic [2:0] sel0, sel1;
  logic pol0, pol1;
  logic [TW-1:0] dly0, dly1;
  logic trig0, trig1;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tmg_trigger_gen #(
    .SLOT_CHIPS (SC), .SLOTS_PER_FRAME (SPF), .SFN_FRAMES (NF), .SEQ_W (SW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .restart (restart),
    .seq_len (seq_len), .eseq_len (eseq_len),
    .sel0 (sel0), .pol0 (pol0), .dly0 (dly0),
    .sel1 (sel1), .pol1 (pol1), .dly1 (dly1),
    .trig0 (trig0), .trig1 (trig1)
  );

  function automatic logic exp_mk(input logic [2:0] s, input logic p, input int d,
                                  input int len, input int elen, input int n, input bit ovf);
    int dd;
    int k;
    logic m;
    dd = (d > FR - 1) ? FR - 1 : d;
    m = 1'b0;
    if (ovf) begin
      m = (n >= 20 && n <= 35) || (n >= 40 && n <= 55);
    end else if (n >= dd) begin
      k = n - dd;
      case (s)
        3'd0: m = (k % SC == 0);
        3'd1: m = (k % FR == 0);
        3'd2: m = (k % ((len < 1) ? 1 : len) == 0);
        3'd3: m = (k % ((elen < 1) ? 1 : elen) == 0);
        3'd4: m = (k % SFNP == 0);
        default: m = 1'b0;
      endcase
    end
    return m ^ p;
  endfunction

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  // one directed scenario: configure, restart, then compare both outputs on every chip
  task automatic run_scen(input string tag,
                          input logic [2:0] s0, input logic p0, input int d0,
                          input logic [2:0] s1, input logic p1, input int d1,
                          input int len, input int elen, input int nchips,
                          input bit stall, input bit ovf);
    int bad0 = 0;
    int bad1 = 0;
    int at0 = -1;
    int at1 = -1;
    logic a0 = 1'b0, e0 = 1'b0, a1 = 1'b0, e1 = 1'b0;
    @(negedge clk);
    sel0 = s0; pol0 = p0; dly0 = TW'(d0);
    sel1 = s1; pol1 = p1; dly1 = TW'(d1);
    seq_len = SW'(len); eseq_len = SW'(elen);
    restart = 1'b1; chip_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    for (int n = 0; n < nchips; n++) begin
      for (int r = 0; r < (stall ? 2 : 1); r++) begin
        logic x0, x1;
        x0 = exp_mk(s0, p0, d0, len, elen, n, ovf);
        x1 = exp_mk(s1, p1, d1, len, elen, n, 1'b0);
        if (trig0 !== x0) begin
          bad0++;
          if (at0 < 0) begin at0 = n; a0 = trig0; e0 = x0; end
        end
        if (trig1 !== x1) begin
          bad1++;
          if (at1 < 0) begin at1 = n; a1 = trig1; e1 = x1; end
        end
        if (stall && r == 0) begin
          chip_en = 1'b0;
          @(posedge clk);
          @(negedge clk);
        end
      end
      chip_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chip_en = 1'b0;
    end
    check(tag, (bad0 == 0) ? 1'b1 : a0, (bad0 == 0) ? 1'b1 : e0,
          $sformatf("trig0 (first mismatch at chip %0d, %0d bad)", at0, bad0));
    check(tag, (bad1 == 0) ? 1'b1 : a1, (bad1 == 0) ? 1'b1 : e1,
          $sformatf("trig1 (first mismatch at chip %0d, %0d bad)", at1, bad1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chip_en = 1'b0; restart = 1'b0;
    seq_len = 8'd5; eseq_len = 8'd7;
    sel0 = 3'd0; pol0 = 1'b0; dly0 = '0;
    sel1 = 3'd7; pol1 = 1'b1; dly1 = '0;
    repeat (3) @(negedge clk);
    check("R11", trig0, 1'b1, "trig0 in reset (slot marker at chip 0)");
    check("R11", trig1, 1'b1, "trig1 in reset (idle, inverted)");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", trig0, 1'b1, "trig0 after reset release");
  endtask

  initial begin
    t_reset();
    // R1 slot and R2 frame, undelayed
    run_scen("R1_R2", 3'd0, 1'b0, 0, 3'd1, 1'b0, 0, 5, 7, 150, 1'b0, 1'b0);
    // R3 SFN restart over two full cycles; R6 inverted slot on the other output
    run_scen("R3_R6", 3'd4, 1'b0, 0, 3'd0, 1'b1, 0, 5, 7, 2 * SFNP + 10, 1'b0, 1'b0);
    // R4 both sequence sources with distinct lengths
    run_scen("R4", 3'd2, 1'b0, 0, 3'd3, 1'b0, 0, 5, 7, 80, 1'b0, 1'b0);
    // R4 lengths 0 and 1 fire every chip
    run_scen("R4_short", 3'd2, 1'b0, 0, 3'd3, 1'b0, 0, 0, 1, 20, 1'b0, 1'b0);
    // R5 unused codes stay inactive under both polarities
    run_scen("R5", 3'd5, 1'b0, 0, 3'd7, 1'b1, 0, 1, 1, 100, 1'b0, 1'b0);
    run_scen("R5_code6", 3'd6, 1'b1, 0, 3'd6, 1'b0, 0, 1, 1, 50, 1'b0, 1'b0);
    // R7 delays including the largest legal value
    run_scen("R7", 3'd0, 1'b0, 3, 3'd1, 1'b0, FR - 1, 5, 7, 3 * FR, 1'b0, 1'b0);
    // R7 out-of-range delay is clamped
    run_scen("R7_clamp", 3'd2, 1'b0, 0, 3'd1, 1'b0, 60, 3, 7, 3 * FR, 1'b0, 1'b0);
    // R8 stalled chip strobes
    run_scen("R8", 3'd0, 1'b0, 2, 3'd1, 1'b1, 0, 5, 7, 120, 1'b1, 1'b0);
    // R9 coincidence of all sources at the restart chip, then discard of stale events
    run_scen("R9", 3'd4, 1'b0, 0, 3'd2, 1'b0, 0, 9, 7, 30, 1'b0, 1'b0);
    run_scen("R9_pre", 3'd2, 1'b0, 10, 3'd7, 1'b0, 0, 7, 7, 9, 1'b0, 1'b0);
    run_scen("R9_flush", 3'd0, 1'b0, 10, 3'd7, 1'b0, 0, 7, 7, 60, 1'b0, 1'b0);
    // R10 queue overflow with an event on every chip
    run_scen("R10", 3'd2, 1'b0, 20, 3'd3, 1'b0, 0, 1, 9, 60, 1'b0, 1'b1);
    // R12 independent settings per output
    run_scen("R12", 3'd0, 1'b1, 5, 3'd3, 1'b0, 2, 4, 9, 100, 1'b0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule